// File: doc/BRIEF.md
# Variable-Length Instruction Assembler

The block sits between instruction memory and the decode stage. It takes one byte per handshake and collects bytes until a whole instruction of one to four bytes has arrived. It then presents that instruction on a registered output as a single beat. The beat carries the condition nibble, the opcode, the packed register nibbles, a 16-bit immediate, the length, an undefined-opcode flag and the address of the instruction's first byte.

The first byte decides the length. Its upper nibble is the condition. Bit 3 selects one of two formats. When bit 3 is clear, the instruction is a one-byte short form, and bits [2:0] hold its opcode. When bit 3 is set, a full opcode follows in the next byte, and that opcode's class fixes how many more bytes to collect. An opcode with no meaning is flagged and taken as two bytes long, so the byte stream stays aligned.

The output register stalls the input while the consumer refuses it. A synchronous flush throws away any bytes collected so far for an unfinished instruction.

Top module: `instr_packer`

## Requirements
- R1: After reset, out_valid is 0 and in_ready is 1. The first instruction reports out_pc equal to RESET_PC (default 0).
- R2: A first byte with bit 3 = 0 is a complete one-byte instruction with these outputs:
  - out_cond is bits [7:4] and out_opcode is bits [2:0], zero-extended.
  - out_min is 1 and out_len is 1.
  - out_ra, out_rb, out_rc and out_imm are 0.
- R3: With bit 3 = 1, full opcodes 0x00-0x05, 0x09, 0x0B and 0x10-0x1B take 3 bytes (out_len 3). out_opcode is the second byte and out_min is 0.
- R4: Full opcodes 0x06, 0x07 and 0x1C-0x22 take 2 bytes (out_len 2).
- R5: Full opcodes 0x08, 0x0A and 0x23 take 4 bytes (out_len 4). The 16-bit immediate is sent low byte first.
- R6: Field positions are fixed:
  - out_ra is byte 2 bits [7:4] and out_rb is byte 2 bits [3:0].
  - out_rc is byte 3 bits [7:4].
  - out_imm is {byte 3, byte 2}.
  - Any field taken from a byte beyond the instruction's length reads 0.
- R7: Any other full opcode (0x0C-0x0F or 0x24-0xFF) sets out_illegal to 1 and is taken as 2 bytes long. Defined opcodes give out_illegal 0.
- R8: out_pc of each instruction equals the previous out_pc plus the previous out_len, modulo 2^16.
- R9: While out_valid is 1 and out_ready is 0, all outputs stay stable and in_ready is 0.
- R10: A cycle with flush high accepts no byte (in_ready 0). Flush discards any partly collected instruction and leaves the program counter unchanged. The next accepted byte is then treated as a first byte.
- R11: Each complete instruction gives exactly one output beat, and the beats come in input order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Discard partial instruction |
| in_valid | input | 1 | Byte available |
| in_byte | input | 8 | Instruction byte |
| in_ready | output | 1 | Byte accepted this cycle when valid |
| out_valid | output | 1 | Instruction beat present |
| out_ready | input | 1 | Consumer takes the beat |
| out_cond | output | 4 | Condition nibble |
| out_min | output | 1 | Short-form instruction |
| out_opcode | output | 8 | Opcode |
| out_ra | output | 4 | Byte 2 high nibble |
| out_rb | output | 4 | Byte 2 low nibble |
| out_rc | output | 4 | Byte 3 high nibble |
| out_imm | output | 16 | {byte 3, byte 2} |
| out_len | output | 3 | Length in bytes |
| out_illegal | output | 1 | Undefined opcode |
| out_pc | output | PC_W | Address of first byte |

## Verification
Short-form bytes are mixed with full opcodes taken from every length class, including the class edges 0x05/0x06, 0x0B/0x0C, 0x1B/0x1C and 0x23/0x24. A wrong length rule therefore shows up as misframing of every instruction that follows it. The same stream is replayed while the consumer stalls in a repeating pattern. This separates correct holding of the output from output that drifts or from input accepted under backpressure. Flushes sent after one and after two bytes of a partial instruction show whether stale bytes leak into the next instruction or into the address.

// File: rtl/instr_packer.sv
module instr_packer #(
  parameter int PC_W = 16,
  parameter logic [PC_W-1:0] RESET_PC = '0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            flush,
  input  logic            in_valid,
  input  logic [7:0]      in_byte,
  output logic            in_ready,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [3:0]      out_cond,
  output logic            out_min,
  output logic [7:0]      out_opcode,
  output logic [3:0]      out_ra,
  output logic [3:0]      out_rb,
  output logic [3:0]      out_rc,
  output logic [15:0]     out_imm,
  output logic [2:0]      out_len,
  output logic            out_illegal,
  output logic [PC_W-1:0] out_pc
);

  function automatic logic [2:0] full_len(input logic [7:0] op);
    if (op <= 8'h05 || op == 8'h09 || op == 8'h0b || (op >= 8'h10 && op <= 8'h1b))
      return 3'd3;
    if (op == 8'h08 || op == 8'h0a || op == 8'h23)
      return 3'd4;
    return 3'd2;
  endfunction

  function automatic logic defined_op(input logic [7:0] op);
    return (op <= 8'h0b) || (op >= 8'h10 && op <= 8'h23);
  endfunction

  logic [1:0]      cnt;
  logic [7:0]      b0, b1, b2;
  logic [PC_W-1:0] pc;

  logic            take, done;
  logic [7:0]      hdr, opc, byte2, byte3;
  logic [2:0]      need;

  assign in_ready = (!out_valid || out_ready) && !flush;
  assign take     = in_valid && in_ready;
  assign hdr      = (cnt == 2'd0) ? in_byte : b0;
  assign opc      = (cnt == 2'd1) ? in_byte : b1;
  assign byte2    = (cnt == 2'd2) ? in_byte : b2;
  assign byte3    = in_byte;
  assign need     = hdr[3] ? full_len(opc) : 3'd1;
  assign done     = take && (({1'b0, cnt} + 3'd1) == need);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt         <= '0;
      b0          <= '0;
      b1          <= '0;
      b2          <= '0;
      pc          <= RESET_PC;
      out_valid   <= 1'b0;
      out_cond    <= '0;
      out_min     <= 1'b0;
      out_opcode  <= '0;
      out_ra      <= '0;
      out_rb      <= '0;
      out_rc      <= '0;
      out_imm     <= '0;
      out_len     <= '0;
      out_illegal <= 1'b0;
      out_pc      <= '0;
    end else begin
      if (out_valid && out_ready) out_valid <= 1'b0;
      if (flush) begin
        cnt <= '0;
      end else if (done) begin
        out_valid   <= 1'b1;
        out_cond    <= hdr[7:4];
        out_min     <= !hdr[3];
        out_opcode  <= hdr[3] ? opc : {5'b0, hdr[2:0]};
        out_ra      <= (need >= 3'd3) ? byte2[7:4] : 4'h0;
        out_rb      <= (need >= 3'd3) ? byte2[3:0] : 4'h0;
        out_rc      <= (need == 3'd4) ? byte3[7:4] : 4'h0;
        out_imm     <= {(need == 3'd4) ? byte3 : 8'h00, (need >= 3'd3) ? byte2 : 8'h00};
        out_len     <= need;
        out_illegal <= hdr[3] && !defined_op(opc);
        out_pc      <= pc;
        pc          <= pc + PC_W'(need);
        cnt         <= '0;
      end else if (take) begin
        case (cnt)
          2'd0:    b0 <= in_byte;
          2'd1:    b1 <= in_byte;
          default: b2 <= in_byte;
        endcase
        cnt <= cnt + 2'd1;
      end
    end
  end

  assert_min_len_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_min) |-> (out_len == 3'd1));
  assert_illegal_len_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_illegal) |-> (out_len == 3'd2 && !out_min));
  assert_len_range_R11: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_len >= 3'd1 && out_len <= 3'd4));
  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable({out_cond, out_min, out_opcode,
      out_ra, out_rb, out_rc, out_imm, out_len, out_illegal, out_pc})));
  assert_stall_blocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);
  assert_flush_no_emit_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (flush && (!out_valid || out_ready)) |=> !out_valid);
  assert_pc_moves_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready) |=> (!out_valid || out_pc != $past(out_pc)));

endmodule

// File: tb/instr_packer_bench.sv
module instr_packer_bench;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [3:0]  cond;
    logic        mn;
    logic [7:0]  op;
    logic [3:0]  ra, rb, rc;
    logic [15:0] imm;
    logic [2:0]  len;
    logic        ill;
    logic [15:0] pc;
  } item_t;

  logic clk = 0, rst_n = 0, flush = 0, in_valid = 0, out_ready = 1;
  logic [7:0] in_byte = 0;
  logic in_ready, out_valid, out_min, out_illegal;
  logic [3:0] out_cond, out_ra, out_rb, out_rc;
  logic [7:0] out_opcode;
  logic [15:0] out_imm, out_pc;
  logic [2:0] out_len;

  int checks = 0, errors = 0, cyc = 0;
  logic stall_on = 0, finished = 0;
  logic [15:0] exp_pc = 0;
  item_t q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  instr_packer u_instr_packer (
    .clk(clk), .rst_n(rst_n), .flush(flush), .in_valid(in_valid), .in_byte(in_byte),
    .in_ready(in_ready), .out_valid(out_valid), .out_ready(out_ready),
    .out_cond(out_cond), .out_min(out_min), .out_opcode(out_opcode),
    .out_ra(out_ra), .out_rb(out_rb), .out_rc(out_rc), .out_imm(out_imm),
    .out_len(out_len), .out_illegal(out_illegal), .out_pc(out_pc));

  task automatic check(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [2:0] spec_len(input logic [7:0] h, input logic [7:0] op);
    if (!h[3]) return 3'd1;
    if ((op >= 8'h00 && op <= 8'h05) || op == 8'h09 || op == 8'h0b || (op >= 8'h10 && op <= 8'h1b)) return 3'd3;
    if (op == 8'h08 || op == 8'h0a || op == 8'h23) return 3'd4;
    return 3'd2;
  endfunction

  task automatic put_byte(input logic [7:0] b);
    @(negedge clk);
    in_valid = 1; in_byte = b;
    #1;
    while (!in_ready) begin @(negedge clk); #1; end
    @(posedge clk);
    #1 in_valid = 0;
  endtask

  task automatic send(input logic [7:0] h, input logic [7:0] o, input logic [7:0] x2, input logic [7:0] x3);
    item_t e;
    logic [2:0] n;
    n = spec_len(h, o);
    e.cond = h[7:4];
    e.mn   = !h[3];
    e.op   = h[3] ? o : {5'b0, h[2:0]};
    e.ra   = (n >= 3) ? x2[7:4] : 4'h0;
    e.rb   = (n >= 3) ? x2[3:0] : 4'h0;
    e.rc   = (n == 4) ? x3[7:4] : 4'h0;
    e.imm  = {(n == 4) ? x3 : 8'h00, (n >= 3) ? x2 : 8'h00};
    e.len  = n;
    e.ill  = h[3] && !((o <= 8'h0b) || (o >= 8'h10 && o <= 8'h23));
    e.pc   = exp_pc;
    exp_pc = exp_pc + 16'(n);
    q.push_back(e);
    put_byte(h);
    if (n >= 2) put_byte(o);
    if (n >= 3) put_byte(x2);
    if (n == 4) put_byte(x3);
  endtask

  task automatic do_flush();
    @(negedge clk);
    flush = 1;
    #1 check(in_ready == 0, "R10 in_ready during flush", 64'(in_ready), 64'd0);
    @(negedge clk);
    flush = 0;
  endtask

  task automatic stream();
    send(8'h00, 0, 0, 0);
    send(8'hA5, 0, 0, 0);
    send(8'h17, 0, 0, 0);
    send(8'h18, 8'h00, 8'h3C, 0);
    send(8'h98, 8'h05, 8'hE1, 0);
    send(8'h28, 8'h06, 0, 0);
    send(8'h08, 8'h08, 8'h34, 8'h12);
    send(8'h38, 8'h23, 8'h5A, 8'h7F);
    send(8'h48, 8'h0A, 8'hCD, 8'hAB);
    send(8'h58, 8'h0B, 8'h62, 0);
    send(8'h68, 8'h0C, 0, 0);
    send(8'h78, 8'h10, 8'h12, 0);
    send(8'h88, 8'h1B, 8'hF0, 0);
    send(8'h98, 8'h1C, 0, 0);
    send(8'hB8, 8'h22, 0, 0);
    send(8'hC8, 8'h24, 0, 0);
    send(8'hD8, 8'hFF, 0, 0);
    send(8'hE8, 8'h0F, 0, 0);
    send(8'hF8, 8'h09, 8'h44, 0);
  endtask

  item_t held;
  logic hold_prev = 0;
  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      out_ready = stall_on ? (cyc % 3 == 2) : 1'b1;
      #1;
      if (rst_n && hold_prev) begin
        check(out_valid == 1 && held == {out_cond, out_min, out_opcode, out_ra, out_rb, out_rc,
              out_imm, out_len, out_illegal, out_pc}, "R9 hold", 64'(out_pc), 64'(held.pc));
      end
      hold_prev = rst_n && out_valid && !out_ready;
      if (hold_prev) begin
        held = {out_cond, out_min, out_opcode, out_ra, out_rb, out_rc, out_imm, out_len, out_illegal, out_pc};
        check(in_ready == 0, "R9 stall blocks input", 64'(in_ready), 64'd0);
      end
      if (rst_n && out_valid && out_ready) begin
        if (q.size() == 0) check(0, "R11 extra beat", 64'(out_pc), 64'hFFFF);
        else begin
          item_t e, a;
          e = q.pop_front();
          a = {out_cond, out_min, out_opcode, out_ra, out_rb, out_rc, out_imm, out_len, out_illegal, out_pc};
          check(a == e, "R2 R3 R4 R5 R6 R7 R8 beat", 64'(a), 64'(e));
        end
      end
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    check(0, "watchdog", 0, 0);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    #1;
    check(out_valid == 0, "R1 reset out_valid", 64'(out_valid), 64'd0);
    check(in_ready == 1, "R1 reset in_ready", 64'(in_ready), 64'd1);
    stream();
    put_byte(8'h18);
    put_byte(8'h10);
    do_flush();
    send(8'h07, 0, 0, 0);
    put_byte(8'h28);
    do_flush();
    send(8'h38, 8'h23, 8'h11, 8'h22);
    stall_on = 1;
    stream();
    stall_on = 0;
    for (int i = 0; i < 50 && q.size() != 0; i++) @(negedge clk);
    repeat (4) @(negedge clk);
    check(q.size() == 0, "R11 all beats seen", 64'(q.size()), 64'd0);
    finish_run();
  end
endmodule